// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address by reading two levels of translation entries from memory. A requester hands it one address at a time, together with a flag saying whether the access is a read or a write. The walker computes the first-level entry address from a programmable table base, fetches that word, checks it, and then computes and fetches the second-level entry. The result is either a physical address or a fault code that names the reason the walk stopped. Pages are always 4 KB.

Memory is reached through a single-word read port. The walker holds an address and a valid flag until memory acknowledges the read, and the returned word arrives in the same cycle as the acknowledge. Entries are not cached, so every translation costs exactly two reads, or one if the first level already fails. When a walk faults, the virtual address and the entry word that failed are latched for later inspection. They stay until a clear pulse arrives or a later fault replaces them.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid`, `mem_rd_valid` and `flt_held` are 0, `flt_va` and `flt_entry` are 0, and the table base is 0.
- R2: The first read of a walk goes to table base + 4 × VA[31:20]. A table base written with `base_wr` while the walker is idle is used by the next walk.
- R3: A first-level entry is valid only when its bits [1:0] equal 2'b01. Any other pattern ends the walk after one read with `rsp_ok`=0 and `rsp_fault` = 32'h0001_0000 (bit 16).
- R4: The second read goes to {L1[31:10], 10'b0} + 4 × VA[19:12].
- R5: A second-level entry whose bit 1 is clear ends the walk with `rsp_fault` = 32'h0002_0000 (bit 17). This holds whatever its permission bits are.
- R6: A valid second-level entry lacks permission when a write finds bit 3 clear or a read finds bit 2 clear. That walk ends with `rsp_fault` = 32'h0004_0000 (bit 18).
- R7: A successful walk gives `rsp_ok`=1, `rsp_fault`=0 and `rsp_pa` = {L2[31:12], VA[11:0]}. On a fault `rsp_pa` is 0.
- R8: Only one walk is in flight. `req_ready` is 1 only while idle, and the response is a single-cycle `rsp_valid` pulse.
- R9: A `base_wr` pulse that arrives while a walk is in progress is ignored. That walk and all later walks keep the old base.
- R10: Every fault latches the faulting VA into `flt_va` and the failing entry into `flt_entry`, and sets `flt_held`. A later fault overwrites them. A `flt_clear` pulse with no fault in the same cycle zeroes all three.
- R11: While a read is pending without an acknowledge, `mem_rd_valid` stays 1 and `mem_rd_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr | input | 1 | Load table base (honoured in idle only) |
| base_din | input | 32 | New table base |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_va | input | 32 | Virtual address |
| req_ready | output | 1 | Walker idle and able to accept |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_ack | input | 1 | Read completes this cycle |
| mem_rd_data | input | 32 | Entry word, valid with the acknowledge |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 32 | Fault code, one-hot in bits 16..18 |
| flt_clear | input | 1 | Clear captured fault record |
| flt_held | output | 1 | A fault record is held |
| flt_va | output | 32 | Captured faulting VA |
| flt_entry | output | 32 | Captured failing entry word |

## Verification
The assertions assume that memory raises `mem_rd_ack` only while `mem_rd_valid` is high, and that it never acknowledges outside a walk. The bench memory model follows this rule. It decides at each falling edge whether to acknowledge the pending read, doing so with a random delay or holding it back completely. The assertions also assume that `req_valid` is honoured only together with `req_ready`. The stimulus therefore raises a request only after it sees the walker idle, and drops it one cycle later. Table contents are written into a sparse bench memory before each walk, so the expected value of every read is known.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int AW        = 32;
  localparam int L1_IDX_W  = 12;
  localparam int L2_IDX_W  = 8;
  localparam int OFF_W     = AW - L1_IDX_W - L2_IDX_W;
  localparam int L2B_LSB   = 10;
  localparam int ENT_BYTES = 4;
  localparam int ENT_SH    = $clog2(ENT_BYTES);
  localparam int L2_VLD_B  = 1;
  localparam int RD_B      = 2;
  localparam int WR_B      = 3;
  localparam int F_L1_B    = 16;
  localparam int F_L2_B    = 17;
  localparam int F_PERM_B  = 18;

  typedef enum logic [4:0] {
    ST_IDLE  = 5'b00001,
    ST_L1    = 5'b00010,
    ST_L2    = 5'b00100,
    ST_DONE  = 5'b01000,
    ST_FAULT = 5'b10000
  } walk_st_t;

  function automatic logic [AW-1:0] l1_entry_addr(input logic [AW-1:0] base,
                                                  input logic [AW-1:0] va);
    return base + {{(AW-L1_IDX_W-ENT_SH){1'b0}}, va[AW-1 -: L1_IDX_W], {ENT_SH{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] l2_entry_addr(input logic [AW-1:0] l1e,
                                                  input logic [AW-1:0] va);
    return {l1e[AW-1:L2B_LSB], {L2B_LSB{1'b0}}}
         + {{(AW-L2_IDX_W-ENT_SH){1'b0}}, va[OFF_W +: L2_IDX_W], {ENT_SH{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] phys_addr(input logic [AW-1:0] l2e,
                                              input logic [AW-1:0] va);
    return {l2e[AW-1:OFF_W], va[OFF_W-1:0]};
  endfunction

  function automatic logic [AW-1:0] fault_word(input int bitpos);
    return {{(AW-1){1'b0}}, 1'b1} << bitpos;
  endfunction
endpackage

// File: rtl/pw_decode.sv
module pw_decode
  import pw_pkg::*;
(
  input  logic [AW-1:0] entry,
  input  logic          is_write,
  output logic          l1_ok,
  output logic          l2_ok,
  output logic          perm_ok
);
  always_comb begin
    l1_ok   = (entry[1:0] == 2'b01);
    l2_ok   = entry[L2_VLD_B];
    perm_ok = is_write ? entry[WR_B] : entry[RD_B];
  end
endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
  import pw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_fire,
  input  logic     rd_ack,
  input  logic     l1_ok,
  input  logic     l2_ok,
  input  logic     perm_ok,
  output walk_st_t state
);
  walk_st_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (req_fire) nxt = ST_L1;
      ST_L1:    if (rd_ack) nxt = l1_ok ? ST_L2 : ST_FAULT;
      ST_L2:    if (rd_ack) nxt = (l2_ok && perm_ok) ? ST_DONE : ST_FAULT;
      ST_DONE:  nxt = ST_IDLE;
      ST_FAULT: nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
endmodule

// File: rtl/pw_capture.sv
module pw_capture
  import pw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_evt,
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] entry,
  input  logic          clear,
  output logic          held,
  output logic [AW-1:0] cap_va,
  output logic [AW-1:0] cap_entry
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      cap_va    <= '0;
      cap_entry <= '0;
    end else if (fault_evt) begin
      held      <= 1'b1;
      cap_va    <= va;
      cap_entry <= entry;
    end else if (clear) begin
      held      <= 1'b0;
      cap_va    <= '0;
      cap_entry <= '0;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_din,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_va,
  output logic          req_ready,
  output logic          mem_rd_valid,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_ack,
  input  logic [AW-1:0] mem_rd_data,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [AW-1:0] rsp_pa,
  output logic [AW-1:0] rsp_fault,
  input  logic          flt_clear,
  output logic          flt_held,
  output logic [AW-1:0] flt_va,
  output logic [AW-1:0] flt_entry
);
  walk_st_t      state_q;
  logic [AW-1:0] base_q, va_q, l1e_q, pa_q, code_q;
  logic          wr_q;
  logic          l1_ok, l2_ok, perm_ok;
  logic          req_fire, l1_evt, l2_evt, fault_evt;

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign l1_evt    = (state_q == ST_L1) && mem_rd_ack;
  assign l2_evt    = (state_q == ST_L2) && mem_rd_ack;
  assign fault_evt = (l1_evt && !l1_ok) || (l2_evt && !(l2_ok && perm_ok));

  pw_decode u_dec (
    .entry    (mem_rd_data),
    .is_write (wr_q),
    .l1_ok    (l1_ok),
    .l2_ok    (l2_ok),
    .perm_ok  (perm_ok)
  );

  pw_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .rd_ack   (mem_rd_ack),
    .l1_ok    (l1_ok),
    .l2_ok    (l2_ok),
    .perm_ok  (perm_ok),
    .state    (state_q)
  );

  pw_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_evt (fault_evt),
    .va        (va_q),
    .entry     (mem_rd_data),
    .clear     (flt_clear),
    .held      (flt_held),
    .cap_va    (flt_va),
    .cap_entry (flt_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      va_q   <= '0;
      wr_q   <= 1'b0;
      l1e_q  <= '0;
      pa_q   <= '0;
      code_q <= '0;
    end else begin
      if (base_wr && req_ready) base_q <= base_din;
      if (req_fire) begin
        va_q   <= req_va;
        wr_q   <= req_write;
        code_q <= '0;
      end
      if (l1_evt) begin
        l1e_q <= mem_rd_data;
        if (!l1_ok) code_q <= fault_word(F_L1_B);
      end
      if (l2_evt) begin
        pa_q <= phys_addr(mem_rd_data, va_q);
        if (!l2_ok)        code_q <= fault_word(F_L2_B);
        else if (!perm_ok) code_q <= fault_word(F_PERM_B);
      end
    end
  end

  always_comb begin
    mem_rd_valid = (state_q == ST_L1) || (state_q == ST_L2);
    mem_rd_addr  = (state_q == ST_L2) ? l2_entry_addr(l1e_q, va_q)
                                      : l1_entry_addr(base_q, va_q);
    rsp_valid    = (state_q == ST_DONE) || (state_q == ST_FAULT);
    rsp_ok       = (state_q == ST_DONE);
    rsp_pa       = (state_q == ST_DONE)  ? pa_q   : '0;
    rsp_fault    = (state_q == ST_FAULT) ? code_q : '0;
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pw_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_rd_valid,
  input logic          mem_rd_ack,
  input logic [AW-1:0] mem_rd_addr,
  input logic          rsp_valid,
  input logic          rsp_ok,
  input logic [AW-1:0] rsp_pa,
  input logic [AW-1:0] rsp_fault,
  input logic          flt_clear,
  input logic          flt_held,
  input logic [AW-1:0] flt_va,
  input logic          fault_evt,
  input logic [4:0]    state_vec
);
  a_r8_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state_vec));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_valid && !rsp_valid));

  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  a_r3_code_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($onehot0(rsp_fault) && (rsp_ok == (rsp_fault == '0))));

  a_r7_pa_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_pa == '0));

  a_r10_held_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (flt_held && rsp_valid && !rsp_ok));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_clear && !fault_evt) |=> (!flt_held && flt_va == '0));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ack   (mem_rd_ack),
  .mem_rd_addr  (mem_rd_addr),
  .rsp_valid    (rsp_valid),
  .rsp_ok       (rsp_ok),
  .rsp_pa       (rsp_pa),
  .rsp_fault    (rsp_fault),
  .flt_clear    (flt_clear),
  .flt_held     (flt_held),
  .flt_va       (flt_va),
  .fault_evt    (fault_evt),
  .state_vec    (state_q)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_din = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        rsp_valid, rsp_ok;
  logic [31:0] rsp_pa, rsp_fault;
  logic        flt_clear = 1'b0;
  logic        flt_held;
  logic [31:0] flt_va, flt_entry;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [4];
  int          nreads = 0;
  bit          stall = 1'b0;
  logic [31:0] cur_base = '0;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (.*);

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (mem_rd_valid && !stall && ($urandom % 4 != 0)) begin
      mem_rd_ack  = 1'b1;
      mem_rd_data = rd(mem_rd_addr);
      if (nreads < 4) rd_log[nreads] = mem_rd_addr;
      nreads++;
    end else begin
      mem_rd_ack  = 1'b0;
      mem_rd_data = $urandom;
    end
  end

  task automatic chk(input bit good, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] a1(input logic [31:0] b, input logic [31:0] va);
    return b + (va >> 20) * 4;
  endfunction
  function automatic logic [31:0] a2(input logic [31:0] e1, input logic [31:0] va);
    return (e1 & 32'hFFFF_FC00) + ((va >> 12) & 32'hFF) * 4;
  endfunction

  task automatic set_l1(input logic [31:0] va, input logic [31:0] e);
    mem[a1(cur_base, va)] = e;
  endtask
  task automatic set_l2(input logic [31:0] va, input logic [31:0] e);
    mem[a2(rd(a1(cur_base, va)), va)] = e;
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input string rq,
                      input bit poke, input logic [31:0] pval);
    logic [31:0] e1, e2, ex_pa, ex_code, ex_ent;
    bit ex_ok;
    int ex_n, wait_n;
    e1 = rd(a1(cur_base, va));
    e2 = rd(a2(e1, va));
    ex_ok = 1'b0; ex_pa = 0; ex_ent = 0; ex_n = 2;
    if (e1[1:0] != 2'b01) begin
      ex_code = 32'h0001_0000; ex_ent = e1; ex_n = 1;
    end else if (!e2[1]) begin
      ex_code = 32'h0002_0000; ex_ent = e2;
    end else if (wr ? !e2[3] : !e2[2]) begin
      ex_code = 32'h0004_0000; ex_ent = e2;
    end else begin
      ex_code = 0; ex_ok = 1'b1; ex_pa = {e2[31:12], va[11:0]};
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (poke) stall = 1'b1;
    nreads = 0;
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8", "ready during walk", {31'b0, req_ready}, 32'h0);
    if (poke) begin
      base_wr = 1'b1; base_din = pval;
      @(negedge clk);
      base_wr = 1'b0; stall = 1'b0;
    end
    wait_n = 0;
    while (!rsp_valid && wait_n < 200) begin
      @(negedge clk); wait_n++;
    end
    chk(rsp_valid, rq, "response arrived", {31'b0, rsp_valid}, 32'h1);
    chk(rsp_ok == ex_ok, rq, "rsp_ok", {31'b0, rsp_ok}, {31'b0, ex_ok});
    chk(rsp_fault == ex_code, rq, "fault code", rsp_fault, ex_code);
    chk(rsp_pa == ex_pa, ex_ok ? "R7" : rq, "rsp_pa", rsp_pa, ex_pa);
    chk(nreads == ex_n, rq, "read count", nreads, ex_n);
    chk(rd_log[0] == a1(cur_base, va), "R2", "first read addr", rd_log[0], a1(cur_base, va));
    if (ex_n == 2)
      chk(rd_log[1] == a2(e1, va), "R4", "second read addr", rd_log[1], a2(e1, va));
    if (!ex_ok) begin
      chk(flt_held && flt_va == va, "R10", "captured va", flt_va, va);
      chk(flt_entry == ex_ent, "R10", "captured entry", flt_entry, ex_ent);
    end
    @(negedge clk);
    chk(!rsp_valid, "R8", "response one cycle", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic load_base(input logic [31:0] b);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    base_wr = 1'b1; base_din = b;
    @(negedge clk);
    base_wr = 1'b0;
    cur_base = b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_valid && !flt_held, "R1", "reset outputs",
        {req_ready, rsp_valid, mem_rd_valid, flt_held}, 32'h8);
    chk(flt_va == 0 && flt_entry == 0, "R1", "reset capture", flt_va | flt_entry, 0);
    rst_n = 1'b1;
    // R1: reset base is zero, so the first read lands at 4*index
    set_l1(32'h0030_0000, 32'h0);
    walk(32'h0030_0000, 1'b0, "R1", 1'b0, 0);

    load_base(32'h0010_0000);
    set_l1(32'h1234_5678, 32'h8000_0401);
    set_l2(32'h1234_5678, 32'hABCD_E00E);
    walk(32'h1234_5678, 1'b0, "R7", 1'b0, 0);
    walk(32'h1234_5678, 1'b1, "R7", 1'b0, 0);

    // R3 invalid L1 patterns 00, 10, 11
    set_l1(32'h0020_0000, 32'h8000_0800); walk(32'h0020_0000, 1'b0, "R3", 1'b0, 0);
    set_l1(32'h0020_0000, 32'h8000_0802); walk(32'h0020_0000, 1'b0, "R3", 1'b0, 0);
    set_l1(32'h0020_0000, 32'h8000_0803); walk(32'h0020_0000, 1'b1, "R3", 1'b0, 0);

    // R5 invalid L2 even with both permissions
    set_l1(32'h0040_1000, 32'h8000_1001);
    set_l2(32'h0040_1000, 32'h5555_500C); walk(32'h0040_1000, 1'b0, "R5", 1'b0, 0);
    set_l2(32'h0040_1000, 32'h5555_5000); walk(32'h0040_1000, 1'b1, "R5", 1'b0, 0);

    // R6 read-only and write-only pages
    set_l2(32'h0040_1000, 32'h6666_6006);
    walk(32'h0040_1ABC, 1'b1, "R6", 1'b0, 0);
    walk(32'h0040_1ABC, 1'b0, "R6", 1'b0, 0);
    set_l2(32'h0040_1000, 32'h7777_700A);
    walk(32'h0040_1ABC, 1'b0, "R6", 1'b0, 0);
    walk(32'h0040_1ABC, 1'b1, "R6", 1'b0, 0);

    // R10 clear then overwrite
    @(negedge clk); flt_clear = 1'b1;
    @(negedge clk); flt_clear = 1'b0;
    chk(!flt_held && flt_va == 0 && flt_entry == 0, "R10", "cleared record",
        flt_va | flt_entry, 0);
    walk(32'h0020_0000, 1'b0, "R10", 1'b0, 0);
    walk(32'h0040_1FFF, 1'b0, "R10", 1'b0, 0);

    // boundary indices
    set_l1(32'hFFFF_FFFF, 32'h8003_FC01);
    set_l2(32'hFFFF_FFFF, 32'hFFFF_F00E);
    walk(32'hFFFF_FFFF, 1'b1, "R4", 1'b0, 0);
    set_l1(32'h0000_0000, 32'h8004_0001);
    set_l2(32'h0000_0000, 32'h0000_1006);
    walk(32'h0000_0000, 1'b0, "R4", 1'b0, 0);

    // R9: base write mid-walk ignored, R11 via stalled read
    walk(32'h1234_5678, 1'b0, "R9", 1'b1, 32'h0F00_0000);
    walk(32'h1234_5678, 1'b0, "R9", 1'b0, 0);
    // R2: idle base write takes effect
    load_base(32'h0200_0000);
    set_l1(32'h1234_5678, 32'h8000_0C01);
    set_l2(32'h1234_5678, 32'h1111_1006);
    walk(32'h1234_5678, 1'b0, "R2", 1'b0, 0);
    load_base(32'h0010_0000);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] va, e1, e2;
      va = $urandom;
      e1 = 32'h9000_0000 | ($urandom & 32'h0FFF_FFFC);
      e1[1:0] = ($urandom % 4 == 0) ? 2'($urandom) : 2'b01;
      e2 = $urandom;
      set_l1(va, e1);
      if (e1[1:0] == 2'b01) set_l2(va, e2);
      walk(va, 1'($urandom), "R6", 1'b0, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule